// File: doc/BRIEF.md
# Pseudo-SRAM Bring-Up and Configuration Sequencer

This block brings a pseudo-SRAM out of power-up before the main memory controller is allowed to use it. After reset it keeps chip enable deasserted for a power-up quiet period counted in system clock cycles. It then loads the two mode registers of the memory with control-register write cycles. In such a cycle the configuration word travels on the address lines, and the control-register enable pin is held high. The refresh-control register is loaded first and the bus-control register second. Both writes use slow asynchronous timing, because the memory wakes up in asynchronous mode.

When both loads are done the sequencer releases the pins to their idle levels and raises `ready_o`. It also exports the burst, wait-polarity, clock-edge and page-mode bits that it programmed, so the bus controller can follow the same settings. A `start_i` pulse in the ready state runs the whole sequence again. A held `dpd_req_i` puts the memory into deep power-down. Releasing it runs the full quiet period and both register loads again.

Top module: `psram_init_seq`

## Requirements
- R1: While `rst_ni` is low: `ce_n_o`, `we_n_o` and `oe_n_o` are 1; `cre_o`, `ready_o`, `clk_o` are 0; `addr_o` is 0.
- R2: After reset release, after a `start_i` restart and after leaving deep power-down, `ce_n_o` stays high for at least PWRUP_CYCLES = CLK_MHZ*PWRUP_US cycles. The first chip-enable fall then comes no more than 4 cycles after that.
- R3: Each initialization makes exactly two control-register writes. The first has `addr_o` = {bit SEL_BIT = 0, bits [CFG_W-1:0] = `rcr_cfg_i`}. The second has bit SEL_BIT = 1 and bits [CFG_W-1:0] = `bcr_cfg_i`. All other address bits are 0 in both.
- R4: In every write cycle `we_n_o` is low for exactly PULSE_CYC consecutive cycles. During that time `ce_n_o` is low, `cre_o` is high, `oe_n_o` is high and `addr_o` does not change.
- R5: `cre_o` is never high while `ce_n_o` is high, except in the deep power-down state.
- R6: `ready_o` rises only after both writes have completed. While it is high, `ce_n_o` and `we_n_o` are high and `cre_o` is low.
- R7: `burst_en_o`, `wait_pol_o`, `clk_edge_o` equal bits 15, 10, 6 of the bus word written. `page_en_o` equals bit 7 of the refresh word written. Changes on `bcr_cfg_i`/`rcr_cfg_i` while ready are ignored until the next initialization.
- R8: A high `dpd_req_i` while ready enters deep power-down on the next edge. In that state `ce_n_o` = 1, `cre_o` = 1 and `ready_o` = 0. Dropping `dpd_req_i` reruns the full initialization.
- R9: `dpd_req_i` pulses during initialization are ignored.
- R10: A `start_i` pulse while ready reruns initialization with the current inputs. `start_i` during initialization is ignored.
- R11: `clk_o` is always 0. `adv_n_o` is low exactly while `ce_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Re-run initialization (accepted when ready) |
| dpd_req_i | input | 1 | Deep power-down request, level (accepted when ready) |
| bcr_cfg_i | input | CFG_W | Bus-control register word |
| rcr_cfg_i | input | CFG_W | Refresh-control register word |
| ce_n_o | output | 1 | Chip enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable, active low (held high) |
| cre_o | output | 1 | Control-register enable |
| adv_n_o | output | 1 | Address valid, active low |
| addr_o | output | ADDR_W | Address pins carrying register words |
| clk_o | output | 1 | Memory clock, held low in asynchronous mode |
| ready_o | output | 1 | Bus handed to main controller |
| burst_en_o | output | 1 | Programmed burst enable |
| wait_pol_o | output | 1 | Programmed wait polarity |
| clk_edge_o | output | 1 | Programmed active clock edge |
| page_en_o | output | 1 | Programmed page-mode enable |

## Verification
The bench measures the quiet interval before every first chip-enable fall. A design that restarts its timer on a stray `start_i`, or that skips the wait after deep power-down, lands outside the allowed window. It watches every cycle for the control-register enable being high with the chip deselected. That is the case a sequencer that drops chip enable and the register enable in the wrong order, or reacts to a power-down pulse in mid-sequence, would put on the pins, and it turns an intended register load into a deep power-down. It records the address and strobe width of each write, which exposes swapped register order, a wrong select bit or a truncated write. It also scrambles the configuration inputs while ready, which catches exported mode bits that follow the live inputs instead of the words actually written.

// File: rtl/psram_init_pkg.sv
package psram_init_pkg;
  typedef enum logic [2:0] {ST_PWRUP, ST_RCR, ST_BCR, ST_READY, ST_DPD} seq_st_e;
  typedef enum logic [2:0] {PH_IDLE, PH_CE_ON, PH_SETUP, PH_PULSE, PH_HOLD, PH_CRE_OFF, PH_GAP} wr_ph_e;
  localparam int unsigned BCR_BURST_BIT   = 15;
  localparam int unsigned BCR_WAITPOL_BIT = 10;
  localparam int unsigned BCR_EDGE_BIT    = 6;
  localparam int unsigned RCR_PAGE_BIT    = 7;
endpackage

// File: rtl/psram_pwrup_timer.sv
module psram_pwrup_timer #(
  parameter int unsigned CYCLES = 15000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= CW'(CYCLES);
    else if (load_i)          cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0) && !load_i;
endmodule

// File: rtl/psram_creg_wr.sv
module psram_creg_wr
  import psram_init_pkg::*;
#(
  parameter int unsigned ADDR_W    = 21,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned HOLD_CYC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] val_i,
  output logic              ce_n_o,
  output logic              we_n_o,
  output logic              cre_o,
  output logic              adv_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam int unsigned MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int unsigned MAX_L = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int unsigned CW    = $clog2(MAX_L + 1);

  wr_ph_e            ph_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (go_i) begin
          ph_q   <= PH_CE_ON;
          addr_q <= val_i;
        end
        PH_CE_ON: begin
          ph_q  <= PH_SETUP;
          cnt_q <= CW'(SETUP_CYC - 1);
        end
        PH_SETUP: if (cnt_q == '0) begin
          ph_q  <= PH_PULSE;
          cnt_q <= CW'(PULSE_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_PULSE: if (cnt_q == '0) begin
          ph_q  <= PH_HOLD;
          cnt_q <= CW'(HOLD_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (cnt_q == '0) ph_q <= PH_CRE_OFF;
                 else cnt_q <= cnt_q - 1'b1;
        PH_CRE_OFF: ph_q <= PH_GAP;
        PH_GAP:     ph_q <= PH_IDLE;
        default:    ph_q <= PH_IDLE;
      endcase
    end
  end

  // CRE rises a cycle after CE falls and drops a cycle before CE rises
  always_comb begin
    ce_n_o  = (ph_q == PH_IDLE) || (ph_q == PH_GAP);
    cre_o   = (ph_q == PH_SETUP) || (ph_q == PH_PULSE) || (ph_q == PH_HOLD);
    we_n_o  = (ph_q != PH_PULSE);
    adv_n_o = ce_n_o;
    addr_o  = ce_n_o ? '0 : addr_q;
    done_o  = (ph_q == PH_GAP);
  end
endmodule

// File: rtl/psram_init_seq.sv
module psram_init_seq
  import psram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned PWRUP_US  = 150,
  parameter int unsigned ADDR_W    = 21,
  parameter int unsigned CFG_W     = 16,
  parameter int unsigned SEL_BIT   = 19,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned HOLD_CYC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dpd_req_i,
  input  logic [CFG_W-1:0]  bcr_cfg_i,
  input  logic [CFG_W-1:0]  rcr_cfg_i,
  output logic              ce_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic              cre_o,
  output logic              adv_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              clk_o,
  output logic              ready_o,
  output logic              burst_en_o,
  output logic              wait_pol_o,
  output logic              clk_edge_o,
  output logic              page_en_o
);
  localparam int unsigned PWRUP_CYCLES = CLK_MHZ * PWRUP_US;

  seq_st_e           st_q, st_d;
  logic              go_q, go_d, tmr_load, tmr_done, wr_done, wr_ce_n, wr_cre;
  logic [ADDR_W-1:0] rcr_word, bcr_word, wr_val;

  psram_pwrup_timer #(.CYCLES(PWRUP_CYCLES)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .done_o(tmr_done)
  );

  always_comb begin
    rcr_word = '0;
    rcr_word[CFG_W-1:0] = rcr_cfg_i;
    bcr_word = '0;
    bcr_word[CFG_W-1:0] = bcr_cfg_i;
    bcr_word[SEL_BIT]   = 1'b1;
    wr_val = (st_q == ST_RCR) ? rcr_word : bcr_word;
  end

  psram_creg_wr #(
    .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_wr (
    .clk_i, .rst_ni, .go_i(go_q), .val_i(wr_val),
    .ce_n_o(wr_ce_n), .we_n_o, .cre_o(wr_cre), .adv_n_o, .addr_o, .done_o(wr_done)
  );

  always_comb begin
    st_d     = st_q;
    go_d     = 1'b0;
    tmr_load = 1'b0;
    unique case (st_q)
      ST_PWRUP: if (tmr_done) begin st_d = ST_RCR; go_d = 1'b1; end
      ST_RCR:   if (wr_done)  begin st_d = ST_BCR; go_d = 1'b1; end
      ST_BCR:   if (wr_done)  st_d = ST_READY;
      ST_READY: if (dpd_req_i) st_d = ST_DPD;
                else if (start_i) begin st_d = ST_PWRUP; tmr_load = 1'b1; end
      ST_DPD:   if (!dpd_req_i) begin st_d = ST_PWRUP; tmr_load = 1'b1; end
      default:  st_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_PWRUP;
      go_q       <= 1'b0;
      burst_en_o <= 1'b0;
      wait_pol_o <= 1'b0;
      clk_edge_o <= 1'b0;
      page_en_o  <= 1'b0;
    end else begin
      st_q <= st_d;
      go_q <= go_d;
      // capture mode bits in the cycle the write latches its word
      if (go_q && st_q == ST_RCR) page_en_o <= rcr_cfg_i[RCR_PAGE_BIT];
      if (go_q && st_q == ST_BCR) begin
        burst_en_o <= bcr_cfg_i[BCR_BURST_BIT];
        wait_pol_o <= bcr_cfg_i[BCR_WAITPOL_BIT];
        clk_edge_o <= bcr_cfg_i[BCR_EDGE_BIT];
      end
    end
  end

  assign ce_n_o  = wr_ce_n;
  assign cre_o   = wr_cre || (st_q == ST_DPD);
  assign oe_n_o  = 1'b1;
  assign clk_o   = 1'b0;
  assign ready_o = (st_q == ST_READY);
endmodule

// File: rtl/psram_init_chk.sv
module psram_init_chk
  import psram_init_pkg::*;
#(
  parameter int unsigned PWRUP_CYCLES = 15000,
  parameter int unsigned ADDR_W       = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input seq_st_e           st_i,
  input logic              ce_n_i,
  input logic              we_n_i,
  input logic              oe_n_i,
  input logic              cre_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ready_i,
  input logic [3:0]        mode_i
);
  logic [31:0] pw_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pw_cnt <= '0;
    else if (st_i == ST_READY || st_i == ST_DPD) pw_cnt <= '0;
    else if (st_i == ST_PWRUP && pw_cnt < PWRUP_CYCLES) pw_cnt <= pw_cnt + 1;
  end

  AST_PWRUP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ce_n_i) |-> pw_cnt >= PWRUP_CYCLES); // R2
  AST_WE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_i |-> (!ce_n_i && cre_i && oe_n_i)); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n_i && $past(!we_n_i)) |-> $stable(addr_i)); // R4
  AST_CRE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cre_i && ce_n_i) |-> (st_i == ST_DPD)); // R5
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> (ce_n_i && we_n_i && !cre_i)); // R6
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && $past(ready_i)) |-> $stable(mode_i)); // R7
  AST_DPD_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_DPD) |-> (ce_n_i && cre_i && !ready_i)); // R8
endmodule

bind psram_init_seq psram_init_chk #(.PWRUP_CYCLES(PWRUP_CYCLES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st_q), .ce_n_i(ce_n_o), .we_n_i(we_n_o),
  .oe_n_i(oe_n_o), .cre_i(cre_o), .addr_i(addr_o), .ready_i(ready_o),
  .mode_i({burst_en_o, wait_pol_o, clk_edge_o, page_en_o})
);

// File: tb/psram_init_seq_test.sv
module psram_init_seq_test;
  localparam int CLK_MHZ = 250, PWRUP_US = 2, P = CLK_MHZ * PWRUP_US;
  localparam int ADDR_W = 21, CFG_W = 16, SEL_BIT = 19;
  localparam int SETUP = 2, PULSE = 3, HOLD = 2;
  localparam int WR_LEN = SETUP + PULSE + HOLD + 3;
  localparam int LAT_MAX = P + 2 * WR_LEN + 8;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, dpd_req_i = 1'b0;
  logic [CFG_W-1:0] bcr_cfg_i = '0, rcr_cfg_i = '0;
  logic ce_n_o, we_n_o, oe_n_o, cre_o, adv_n_o, clk_o, ready_o;
  logic burst_en_o, wait_pol_o, clk_edge_o, page_en_o;
  logic [ADDR_W-1:0] addr_o;

  always #2 clk = ~clk;

  psram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .ADDR_W(ADDR_W), .CFG_W(CFG_W), .SEL_BIT(SEL_BIT),
    .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD)
  ) uut (
    .clk_i(clk), .rst_ni, .start_i, .dpd_req_i, .bcr_cfg_i, .rcr_cfg_i,
    .ce_n_o, .we_n_o, .oe_n_o, .cre_o, .adv_n_o, .addr_o, .clk_o, .ready_o,
    .burst_en_o, .wait_pol_o, .clk_edge_o, .page_en_o
  );

  int checks = 0, fails = 0, cyc = 0, quiet = 0, wr_seen = 0, we_len = 0;
  bit fresh = 0, dpd_exp = 0, mon_en = 0, done = 0;
  logic [ADDR_W-1:0] wr_addr [2];
  logic [ADDR_W-1:0] last_addr;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [ADDR_W-1:0] exp_word(input bit sel, input logic [CFG_W-1:0] cfg);
    logic [ADDR_W-1:0] w;
    w = '0;
    w[CFG_W-1:0] = cfg;
    w[SEL_BIT] = sel;
    return w;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
    if (mon_en) begin
      if (ce_n_o) quiet++;
      else begin
        if (fresh) begin
          chk(quiet >= P && quiet <= P + 4, "R2 quiet", quiet, P);
          fresh = 0;
        end
        quiet = 0;
      end
      if (!we_n_o) begin
        if (we_len == 0) begin
          chk(!ce_n_o && cre_o && oe_n_o, "R4 strobe", {ce_n_o, cre_o, oe_n_o}, 3'b011);
          if (wr_seen < 2) wr_addr[wr_seen] = addr_o;
          wr_seen++;
          last_addr = addr_o;
        end else chk(addr_o == last_addr, "R4 addr stable", addr_o, last_addr);
        we_len++;
      end else if (we_len != 0) begin
        chk(we_len == PULSE, "R4 width", we_len, PULSE);
        we_len = 0;
      end
      chk(!(cre_o && ce_n_o && !dpd_exp), "R5 cre deselected", cre_o, 0);
      chk(clk_o == 1'b0 && adv_n_o == ce_n_o, "R11 clk/adv", {clk_o, adv_n_o}, {1'b0, ce_n_o});
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic prep();
    fresh = 1; quiet = 0; wr_seen = 0;
  endtask

  task automatic wait_ready(input int t0, output int lat);
    int n = 0;
    while (!ready_o && n < LAT_MAX + 200) begin step(1); n++; end
    lat = cyc - t0;
  endtask

  task automatic check_done(input string req, input logic [CFG_W-1:0] rc, input logic [CFG_W-1:0] bc, input int lat);
    chk(ready_o, {req, " ready"}, ready_o, 1);
    chk(lat <= LAT_MAX, {req, " latency"}, lat, LAT_MAX);
    chk(wr_seen == 2, "R3/R6 write count", wr_seen, 2);
    chk(wr_addr[0] == exp_word(1'b0, rc), "R3 refresh word", wr_addr[0], exp_word(1'b0, rc));
    chk(wr_addr[1] == exp_word(1'b1, bc), "R3 bus word", wr_addr[1], exp_word(1'b1, bc));
    chk(ce_n_o && we_n_o && !cre_o, "R6 idle pins", {ce_n_o, we_n_o, cre_o}, 3'b110);
    chk({burst_en_o, wait_pol_o, clk_edge_o, page_en_o} == {bc[15], bc[10], bc[6], rc[7]},
        "R7 mode bits", {burst_en_o, wait_pol_o, clk_edge_o, page_en_o}, {bc[15], bc[10], bc[6], rc[7]});
  endtask

  task automatic run_start(input logic [CFG_W-1:0] rc, input logic [CFG_W-1:0] bc);
    int t0, lat;
    rcr_cfg_i = rc; bcr_cfg_i = bc;
    prep(); t0 = cyc;
    start_i = 1; step(1); start_i = 0;
    wait_ready(t0, lat);
    check_done("R10", rc, bc, lat);
  endtask

  initial begin
    int t0, lat;
    logic [CFG_W-1:0] rc, bc;
    void'($urandom(32'd4242));
    rcr_cfg_i = 16'h0080; bcr_cfg_i = 16'h8440;
    step(3);
    chk(ce_n_o && we_n_o && oe_n_o && !cre_o && !ready_o && !clk_o && addr_o == '0, "R1 reset",
        {ce_n_o, we_n_o, oe_n_o, cre_o, ready_o, clk_o}, 6'b111000);
    prep(); mon_en = 1; t0 = cyc;
    rst_ni = 1;
    wait_ready(t0, lat);
    check_done("R2", 16'h0080, 16'h8440, lat);

    // R7: live inputs ignored while ready
    for (int i = 0; i < 20; i++) begin
      rcr_cfg_i = 16'($urandom); bcr_cfg_i = 16'($urandom);
      step(1);
      chk({burst_en_o, wait_pol_o, clk_edge_o, page_en_o} == 4'b1111, "R7 hold", {burst_en_o, wait_pol_o, clk_edge_o, page_en_o}, 4'b1111);
    end
    chk(wr_seen == 2 && ready_o, "R7 no rewrite", wr_seen, 2);

    run_start(16'h0000, 16'h0000);
    run_start(16'hFFFF, 16'hFFFF);
    for (int i = 0; i < 4; i++) run_start(16'($urandom), 16'($urandom));

    // R10: start during power-up wait and during a write is ignored
    rc = 16'($urandom); bc = 16'($urandom);
    rcr_cfg_i = rc; bcr_cfg_i = bc;
    prep(); t0 = cyc;
    start_i = 1; step(1); start_i = 0;
    step(100); start_i = 1; step(1); start_i = 0;
    while (we_n_o) step(1);
    start_i = 1; step(1); start_i = 0;
    wait_ready(t0, lat);
    check_done("R10 ignored", rc, bc, lat);

    // R9: power-down pulses during initialization are ignored
    rc = 16'($urandom); bc = 16'($urandom);
    rcr_cfg_i = rc; bcr_cfg_i = bc;
    prep(); t0 = cyc;
    start_i = 1; step(1); start_i = 0;
    step(50); dpd_req_i = 1; step(5); dpd_req_i = 0;
    while (we_n_o) step(1);
    dpd_req_i = 1; step(3); dpd_req_i = 0;
    wait_ready(t0, lat);
    check_done("R9", rc, bc, lat);

    // R8: deep power-down entry, hold, exit
    dpd_exp = 1; dpd_req_i = 1; step(1);
    chk(ce_n_o && cre_o && !ready_o, "R8 enter", {ce_n_o, cre_o, ready_o}, 3'b110);
    rc = 16'($urandom); bc = 16'($urandom);
    rcr_cfg_i = rc; bcr_cfg_i = bc;
    step(30);
    chk(ce_n_o && cre_o && !ready_o, "R8 hold", {ce_n_o, cre_o, ready_o}, 3'b110);
    prep(); t0 = cyc;
    dpd_req_i = 0; step(1); dpd_exp = 0;
    chk(!cre_o && ce_n_o, "R8 exit pins", {ce_n_o, cre_o}, 2'b10);
    wait_ready(t0, lat);
    check_done("R8", rc, bc, lat);

    step(5);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule